// File: doc/BRIEF.md
# Strobed Input Port Handshake

This block receives bytes from an external device on a parallel input port. The device drives a byte on the port pins, then pulses an active-low strobe. The block brings the strobe into the clock domain and captures the pins on the strobe's falling edge. It then sets a buffer-full flag, which tells the device that a byte is being held for the processor.

Once the strobe has returned high, the block raises an interrupt request, provided interrupts are enabled. The processor then reads the held byte with an active-low read pulse. The start of that pulse withdraws the request. The end of the pulse clears buffer-full, which tells the device that the byte was both captured and consumed.

If a second strobe arrives before the processor has read the held byte, the new byte replaces the old one. A sticky overrun flag records the lost byte until the next reset.

Top module: `strobed_in_port`

## Requirements
- R1: Reset clears buffer-full, the interrupt request and the overrun flag, and sets the held byte to zero.
- R2: A falling edge of the strobe captures the port pins into the held byte and sets buffer-full. The strobe passes through a synchronizer of SYNC_STAGES flops, so buffer-full rises on the (SYNC_STAGES+1)th rising clock edge after the strobe falls, and not earlier.
- R3: The interrupt request rises one clock edge after all of these hold together: the enable input is 1, buffer-full is 1, the synchronized strobe is high, and the read strobe has been high for two consecutive edges. While the strobe is still low or the enable input is 0, the request stays 0.
- R4: The first clock edge that samples the read strobe low drives the interrupt request to 0. The request stays 0 for as long as the read strobe stays low.
- R5: Buffer-full stays 1 while the read strobe is low. It clears on the first clock edge that samples the read strobe high again.
- R6: The bus output always shows the held byte. It never shows the live pins, so a change on the pins without a strobe leaves it unchanged.
- R7: A strobe that falls while buffer-full is set, with no read ending on the same edge, replaces the held byte and sets the overrun flag. The overrun flag then stays 1 until reset, including through later reads.
- R8: When a strobe capture and the end of a read fall on the same edge, the capture wins. Buffer-full stays 1, the new byte is held, and the overrun flag is not set.
- R9: When the enable input drops, the interrupt request falls on the next clock edge. Buffer-full is not affected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_data | input | DATA_W | Byte driven by the external device |
| stb_n | input | 1 | Active-low strobe from the device, asynchronous |
| rd_n | input | 1 | Active-low processor read strobe, synchronous to clk |
| int_en | input | 1 | Interrupt enable |
| bus_data | output | DATA_W | Held byte returned to the processor |
| buf_full | output | 1 | Byte held and not yet read |
| irq | output | 1 | Interrupt request to the processor |
| overrun | output | 1 | Sticky flag: a held byte was overwritten before it was read |

## Verification
The bench samples buffer-full on the exact edges around the synchronizer delay. A design with one register too few or too many in the strobe path would flag the byte one cycle early or late. It holds the strobe low for a long time and checks that the interrupt waits for the strobe to return high. A design that raised the request on capture would fail that check.

The bench lines up a strobe capture with the end of a read on the same edge. A design that gave the read priority would leave a fresh byte marked empty, and one that counted the case as a collision would report a false overrun. It sweeps every byte value through a full handshake while moving the pins after capture. This exposes a design that passes the live pins to the bus or loses bits in the capture register.

// File: rtl/sip_pkg.sv
package sip_pkg;

    // Handshake state bits held by the core
    typedef struct packed {
        logic full;      // byte held, not yet read
        logic irq;       // interrupt request
        logic ovr;       // sticky overrun
        logic rd_prev;   // read strobe seen on the previous edge
        logic stb_prev;  // synchronized strobe seen on the previous edge
    } sip_state_t;

    localparam sip_state_t SIP_STATE_RST = '{
        full:     1'b0,
        irq:      1'b0,
        ovr:      1'b0,
        rd_prev:  1'b1,
        stb_prev: 1'b1
    };

endpackage

// File: rtl/sip_sync.sv
module sip_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = async_in;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/sip_core.sv
module sip_core
    import sip_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_s,
    input  logic              rd_n,
    input  logic              int_en,
    input  logic [DATA_W-1:0] pin_data,
    output logic [DATA_W-1:0] data_q,
    output sip_state_t        st_q
);

    sip_state_t        st_d;
    logic [DATA_W-1:0] data_d;
    logic              stb_fall;
    logic              rd_rise;

    always_comb begin
        st_d   = st_q;
        data_d = data_q;

        stb_fall = st_q.stb_prev & ~stb_s;
        rd_rise  = ~st_q.rd_prev & rd_n;

        st_d.stb_prev = stb_s;
        st_d.rd_prev  = rd_n;

        // end of a read empties the buffer
        if (rd_rise) begin
            st_d.full = 1'b0;
        end

        // capture has priority over the end of a read
        if (stb_fall) begin
            data_d    = pin_data;
            st_d.full = 1'b1;
            if (st_q.full && !rd_rise) begin
                st_d.ovr = 1'b1;
            end
        end

        // request only once strobe is back high and no read is under way
        st_d.irq = int_en & st_q.full & stb_s & rd_n & st_q.rd_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= SIP_STATE_RST;
            data_q <= '0;
        end else begin
            st_q   <= st_d;
            data_q <= data_d;
        end
    end

endmodule

// File: rtl/strobed_in_port.sv
module strobed_in_port
    import sip_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pin_data,
    input  logic              stb_n,
    input  logic              rd_n,
    input  logic              int_en,
    output logic [DATA_W-1:0] bus_data,
    output logic              buf_full,
    output logic              irq,
    output logic              overrun
);

    logic       stb_s;
    sip_state_t st;

    sip_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (stb_n),
        .sync_out (stb_s)
    );

    sip_core #(
        .DATA_W (DATA_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb_s    (stb_s),
        .rd_n     (rd_n),
        .int_en   (int_en),
        .pin_data (pin_data),
        .data_q   (bus_data),
        .st_q     (st)
    );

    assign buf_full = st.full;
    assign irq      = st.irq;
    assign overrun  = st.ovr;

endmodule

// File: rtl/sip_chk.sv
module sip_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_n,
    input logic              int_en,
    input logic [DATA_W-1:0] bus_data,
    input logic              buf_full,
    input logic              irq,
    input logic              overrun
);

    // R3: a request only follows an enabled, full buffer
    a_r3_irq_needs_cond: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(int_en) && $past(buf_full) && buf_full));

    // R4: read strobe low forces the request off next edge
    a_r4_read_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |=> !irq);

    // R5: buffer-full is held while the read is still low
    a_r5_full_held_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && !rd_n) |=> buf_full);

    // R6: held byte changes only together with a capture
    a_r6_data_moves_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bus_data) |-> buf_full);

    // R7: overrun is sticky
    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R9: enable low means no request on the next edge
    a_r9_enable_gates_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |=> !irq);

endmodule

bind strobed_in_port sip_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_n     (rd_n),
    .int_en   (int_en),
    .bus_data (bus_data),
    .buf_full (buf_full),
    .irq      (irq),
    .overrun  (overrun)
);

// File: tb/tb_strobed_in_port.sv
`timescale 1ns/1ps
module tb_strobed_in_port;

    localparam int DATA_W = 8;
    localparam int NVALS  = 1 << DATA_W;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [DATA_W-1:0] pin_data;
    logic              stb_n;
    logic              rd_n;
    logic              int_en;
    logic [DATA_W-1:0] bus_data;
    logic              buf_full;
    logic              irq;
    logic              overrun;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    strobed_in_port #(.DATA_W(DATA_W), .SYNC_STAGES(2)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_data (pin_data),
        .stb_n    (stb_n),
        .rd_n     (rd_n),
        .int_en   (int_en),
        .bus_data (bus_data),
        .buf_full (buf_full),
        .irq      (irq),
        .overrun  (overrun)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    // strobe low for two cycles, then wait until the request can appear
    task automatic strobe(input logic [DATA_W-1:0] v);
        @(negedge clk);
        pin_data = v;
        stb_n    = 1'b0;
        step(2);
        stb_n = 1'b1;
        step(4);
    endtask

    // full read pulse with its own checks
    task automatic do_read(input logic [DATA_W-1:0] exp_v);
        @(negedge clk);
        rd_n = 1'b0;
        step(1);
        check("R4 irq low after read start", irq, 0);
        check("R5 full held during read", buf_full, 1);
        step(2);
        check("R4 irq stays low during read", irq, 0);
        rd_n = 1'b1;
        step(1);
        check("R5 full cleared at read end", buf_full, 0);
        check("R6 bus holds byte after read", bus_data, exp_v);
    endtask

    initial begin
        rst_n    = 1'b0;
        pin_data = '0;
        stb_n    = 1'b1;
        rd_n     = 1'b1;
        int_en   = 1'b1;
        step(3);
        // R1 reset state
        check("R1 full after reset", buf_full, 0);
        check("R1 irq after reset", irq, 0);
        check("R1 overrun after reset", overrun, 0);
        check("R1 data after reset", bus_data, 0);
        rst_n = 1'b1;
        step(2);

        // R2 exact capture timing, R3 request after strobe returns
        @(negedge clk);
        pin_data = 8'hA5;
        stb_n    = 1'b0;
        step(2);
        check("R2 full not yet set", buf_full, 0);
        stb_n = 1'b1;
        step(1);
        check("R2 full set", buf_full, 1);
        check("R2 byte captured", bus_data, 8'hA5);
        check("R3 no irq while strobe sync low", irq, 0);
        step(1);
        check("R3 no irq one edge early", irq, 0);
        step(1);
        check("R3 irq raised", irq, 1);
        pin_data = 8'h00;
        step(1);
        check("R6 pins changed, bus unchanged", bus_data, 8'hA5);
        do_read(8'hA5);
        step(2);
        check("R3 no irq after read", irq, 0);

        // R3 long strobe: request waits for release
        @(negedge clk);
        pin_data = 8'h5A;
        stb_n    = 1'b0;
        step(3);
        for (int i = 0; i < 8; i++) begin
            check("R3 no irq with strobe held low", irq, 0);
            check("R2 full with strobe held low", buf_full, 1);
            step(1);
        end
        stb_n = 1'b1;
        step(2);
        check("R3 no irq before strobe sync high", irq, 0);
        step(1);
        check("R3 irq after long strobe", irq, 1);
        do_read(8'h5A);

        // R3 / R9 enable gating
        int_en = 1'b0;
        strobe(8'h3C);
        step(2);
        check("R3 no irq while disabled", irq, 0);
        check("R9 full kept while disabled", buf_full, 1);
        int_en = 1'b1;
        step(1);
        check("R3 irq one edge after enable", irq, 1);
        int_en = 1'b0;
        step(1);
        check("R9 irq drops after enable low", irq, 0);
        check("R9 full unaffected", buf_full, 1);
        int_en = 1'b1;
        do_read(8'h3C);

        // R7 overrun
        strobe(8'h11);
        check("R7 no overrun on first byte", overrun, 0);
        strobe(8'h22);
        check("R7 byte replaced", bus_data, 8'h22);
        check("R7 overrun set", overrun, 1);
        do_read(8'h22);
        check("R7 overrun sticky after read", overrun, 1);
        strobe(8'h33);
        do_read(8'h33);
        check("R7 overrun sticky after clean transfer", overrun, 1);

        do_reset();
        check("R1 overrun cleared by reset", overrun, 0);
        check("R1 full cleared by reset", buf_full, 0);

        // R8 capture and read end on the same edge
        strobe(8'hC3);
        @(negedge clk);
        rd_n = 1'b0;
        step(1);
        pin_data = 8'h96;
        stb_n    = 1'b0;
        step(2);
        rd_n = 1'b1;
        step(1);
        check("R8 full stays set", buf_full, 1);
        check("R8 new byte held", bus_data, 8'h96);
        check("R8 no overrun", overrun, 0);
        stb_n = 1'b1;
        step(4);
        check("R3 irq for colliding byte", irq, 1);
        do_read(8'h96);
        check("R8 overrun still clear", overrun, 0);

        // sweep of every byte value
        for (int v = 0; v < NVALS; v++) begin
            strobe(DATA_W'(v));
            check("R2 sweep capture", bus_data, v);
            check("R3 sweep irq", irq, 1);
            pin_data = ~DATA_W'(v);
            do_read(DATA_W'(v));
        end
        check("R7 no overrun after sweep", overrun, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule